// File: doc/BRIEF.md
# Page Write Staging Buffer with Commit Timer

This block sits between a serial-memory protocol controller and a byte-addressable storage array. The controller opens a load session by presenting a start address. It then strobes in data bytes and finally asks for a commit, or for an abort. The bytes are held in a 32-entry staging buffer and are not written anywhere until the commit.

At the start of a session the block latches the page number from the upper address bits. Each data byte lands at the current in-page offset, and the offset then steps forward. Past the last entry of the page it wraps back to entry 0 of the same page, so the session never moves into the next page. A valid bit per entry records which offsets were loaded. If an offset is loaded twice, the later byte replaces the earlier one.

On commit the block raises `busy` for a write time taken from `writeTicks`, counted in clocks. In the first 32 cycles of that window it walks the offsets in ascending order and emits one memory write strobe for each loaded entry. All session inputs are ignored while `busy` is high. When the window ends the valid bits are cleared. An abort, or a commit with nothing loaded, empties the buffer and does not raise `busy`.

Top module: `pageWriteStager`

## Requirements
- R1: After reset `busy` and `memWe` are 0.
- R2: `loadStart` outside a busy window latches `startAddr[12:5]` as the page and `startAddr[4:0]` as the first offset. Every committed write address has the latched page in bits 12:5. Each accepted `dataValid` byte goes to the current offset, and the offset then increments by one.
- R3: The offset wraps from 31 to 0 and stays in the same page.
- R4: When an offset is loaded more than once, the commit writes it exactly once, with the last byte loaded there.
- R5: A commit writes only the loaded offsets. There is one `memWe` pulse per clock, in ascending offset order, and it is high only while `busy` is 1.
- R6: `busy` rises in the cycle after the clock edge that samples `commitReq`. It then stays high for max(`writeTicks`, 32) cycles, using the value of `writeTicks` sampled at that edge.
- R7: `abortReq` during a session discards all loaded bytes. No write follows, `busy` stays 0, and a later session writes only its own bytes.
- R8: A `commitReq` with no loaded byte, or with no session open, leaves `busy` at 0 and produces no write.
- R9: While `busy` is 1, `loadStart`, `dataValid`, `abortReq` and `commitReq` have no effect. They do not change the addresses, data or count of the writes in progress, nor the length of `busy`.
- R10: When the busy window ends, all valid bits are cleared, so a following commit without new bytes writes nothing.
- R11: `dataValid` outside a load session is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| loadStart | input | 1 | Opens or restarts a load session at `startAddr` |
| startAddr | input | 13 | Byte address of the first data byte |
| dataValid | input | 1 | One data byte is present on `dataByte` |
| dataByte | input | 8 | Data byte to stage |
| abortReq | input | 1 | Discards the current session |
| commitReq | input | 1 | Commits the staged bytes |
| writeTicks | input | 20 | Write time in clocks (floor of 32) |
| busy | output | 1 | Internal write cycle in progress |
| memWe | output | 1 | Memory write strobe |
| memAddr | output | 13 | Memory write address |
| memData | output | 8 | Memory write data |

## Verification
The main function is driven with several load patterns. A short run starting mid-page shows the page latch and the offset step. A run that crosses offset 31 shows the wrap stays in the page and that the writes come out in ascending offset order, not in load order. A 33-byte run shows that a revisited offset keeps only its last value. Further sequences cover abort, empty commit, stray bytes outside a session and stimulus during a busy window; each is checked by the absence of writes and of `busy`, and a busy window shorter than 32 checks the floor on the write time.

// File: rtl/pageStagePkg.sv
package pageStagePkg;

  typedef struct packed {
    logic latchStart;
    logic pushByte;
    logic clearAll;
    logic scanEn;
  } stageCtrl_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOAD   = 2'd1,
    ST_COMMIT = 2'd2
  } stageState_e;

endpackage

// File: rtl/pageStageControl.sv
module pageStageControl
  import pageStagePkg::*;
#(
  parameter int PAGE_BYTES = 32,
  parameter int TICK_W     = 20,
  localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadStart,
  input  logic              dataValid,
  input  logic              abortReq,
  input  logic              commitReq,
  input  logic [TICK_W-1:0] writeTicks,
  input  logic              maskAny,
  output stageCtrl_t        ctrl,
  output logic [OFF_W-1:0]  scanIdx,
  output logic              busy
);

  localparam logic [TICK_W-1:0] PAGE_TICKS = TICK_W'(PAGE_BYTES);

  stageState_e       state, stateNext;
  logic [TICK_W-1:0] tick;
  logic [TICK_W-1:0] limReg;
  logic [TICK_W-1:0] limNext;

  assign limNext = (writeTicks < PAGE_TICKS) ? PAGE_TICKS : writeTicks;
  assign busy    = (state == ST_COMMIT);
  assign scanIdx = tick[OFF_W-1:0];

  always_comb begin
    ctrl      = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (loadStart) begin
          ctrl.latchStart = 1'b1;
          stateNext       = ST_LOAD;
        end
      end
      ST_LOAD: begin
        if (abortReq) begin
          ctrl.clearAll = 1'b1;
          stateNext     = ST_IDLE;
        end else if (commitReq) begin
          if (maskAny) begin
            stateNext = ST_COMMIT;
          end else begin
            ctrl.clearAll = 1'b1;
            stateNext     = ST_IDLE;
          end
        end else if (loadStart) begin
          ctrl.latchStart = 1'b1;
        end else if (dataValid) begin
          ctrl.pushByte = 1'b1;
        end
      end
      ST_COMMIT: begin
        ctrl.scanEn = (tick < PAGE_TICKS);
        if (tick == limReg - 1'b1) begin
          ctrl.clearAll = 1'b1;
          stateNext     = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      tick   <= '0;
      limReg <= PAGE_TICKS;
    end else begin
      state <= stateNext;
      if (state == ST_COMMIT) begin
        tick <= tick + 1'b1;
      end else begin
        tick <= '0;
      end
      if (state == ST_LOAD && stateNext == ST_COMMIT) begin
        limReg <= limNext;
      end
    end
  end

  // R9: no session strobe leaves the control while the write window runs
  a_r9_busy_blocks_load: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (!ctrl.latchStart && !ctrl.pushByte));

  // R8: with nothing staged the write window cannot open
  a_r8_empty_no_busy: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !maskAny) |=> !busy);

endmodule

// File: rtl/pageStageDatapath.sv
module pageStageDatapath
  import pageStagePkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 32,
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int PAGE_W    = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  stageCtrl_t        ctrl,
  input  logic [OFF_W-1:0]  scanIdx,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [DATA_W-1:0] dataByte,
  output logic              maskAny,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData
);

  logic [PAGE_W-1:0]     pageReg;
  logic [OFF_W-1:0]      offset;
  logic [PAGE_BYTES-1:0] validMask;
  logic [DATA_W-1:0]     laneData [PAGE_BYTES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageReg <= '0;
      offset  <= '0;
    end else if (ctrl.latchStart) begin
      pageReg <= startAddr[ADDR_W-1:OFF_W];
      offset  <= startAddr[OFF_W-1:0];
    end else if (ctrl.pushByte) begin
      offset  <= offset + 1'b1;
    end
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : gLane
    logic hit;
    assign hit = ctrl.pushByte && (offset == OFF_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        validMask[g] <= 1'b0;
      end else if (ctrl.clearAll || ctrl.latchStart) begin
        validMask[g] <= 1'b0;
      end else if (hit) begin
        validMask[g] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (hit) begin
        laneData[g] <= dataByte;
      end
    end
  end

  assign maskAny = |validMask;
  assign memWe   = ctrl.scanEn && validMask[scanIdx];
  assign memAddr = {pageReg, scanIdx};
  assign memData = laneData[scanIdx];

  // R3: a pushed byte marks the offset it was stored at
  a_r3_push_marks_lane: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.pushByte |=> validMask[$past(offset)]);

  // R5: the mask cannot move while the scan walks it
  a_r5_mask_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.scanEn && !ctrl.clearAll) |=> $stable(validMask));

  // R10: after a clear nothing is left staged
  a_r10_clear_empties: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.clearAll |=> !maskAny);

endmodule

// File: rtl/pageWriteStager.sv
module pageWriteStager
  import pageStagePkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 32,
  parameter int TICK_W     = 20,
  localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadStart,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              dataValid,
  input  logic [DATA_W-1:0] dataByte,
  input  logic              abortReq,
  input  logic              commitReq,
  input  logic [TICK_W-1:0] writeTicks,
  output logic              busy,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData
);

  stageCtrl_t       ctrl;
  logic [OFF_W-1:0] scanIdx;
  logic             maskAny;

  pageStageControl #(
    .PAGE_BYTES(PAGE_BYTES),
    .TICK_W    (TICK_W)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .loadStart (loadStart),
    .dataValid (dataValid),
    .abortReq  (abortReq),
    .commitReq (commitReq),
    .writeTicks(writeTicks),
    .maskAny   (maskAny),
    .ctrl      (ctrl),
    .scanIdx   (scanIdx),
    .busy      (busy)
  );

  pageStageDatapath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PAGE_BYTES(PAGE_BYTES)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .scanIdx  (scanIdx),
    .startAddr(startAddr),
    .dataByte (dataByte),
    .maskAny  (maskAny),
    .memWe    (memWe),
    .memAddr  (memAddr),
    .memData  (memData)
  );

  // R5: a memory write strobe only inside the busy window
  a_r5_we_in_busy: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> busy);

  // R1: quiet outputs out of reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |-> (!busy && !memWe));

endmodule

// File: tb/sim_pageWriteStager.sv
module sim_pageWriteStager;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadStart = 1'b0;
  logic [12:0] startAddr = '0;
  logic        dataValid = 1'b0;
  logic [7:0]  dataByte = '0;
  logic        abortReq = 1'b0;
  logic        commitReq = 1'b0;
  logic [19:0] writeTicks = 20'd40;
  logic        busy;
  logic        memWe;
  logic [12:0] memAddr;
  logic [7:0]  memData;

  int nChecks = 0;
  int nFails  = 0;

  logic [12:0] logAddr [64];
  logic [7:0]  logData [64];
  int          logN = 0;
  int          busyCnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pageWriteStager u0 (
    .clk(clk), .rstN(rstN), .loadStart(loadStart), .startAddr(startAddr),
    .dataValid(dataValid), .dataByte(dataByte), .abortReq(abortReq),
    .commitReq(commitReq), .writeTicks(writeTicks), .busy(busy),
    .memWe(memWe), .memAddr(memAddr), .memData(memData)
  );

  always @(negedge clk) begin
    if (rstN) begin
      if (busy) busyCnt++;
      if (memWe && logN < 64) begin
        logAddr[logN] = memAddr;
        logData[logN] = memData;
        logN++;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clearLog();
    @(negedge clk); #1;
    logN = 0;
    busyCnt = 0;
  endtask

  task automatic doStart(input logic [12:0] a);
    @(negedge clk); #1; loadStart = 1'b1; startAddr = a;
    @(negedge clk); #1; loadStart = 1'b0;
  endtask

  task automatic doByte(input logic [7:0] d);
    @(negedge clk); #1; dataValid = 1'b1; dataByte = d;
    @(negedge clk); #1; dataValid = 1'b0;
  endtask

  task automatic doAbort();
    @(negedge clk); #1; abortReq = 1'b1;
    @(negedge clk); #1; abortReq = 1'b0;
  endtask

  task automatic doCommit();
    @(negedge clk); #1; commitReq = 1'b1;
    @(negedge clk); #1; commitReq = 1'b0;
  endtask

  task automatic testReset();
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 memWe after reset", int'(memWe), 0);
  endtask

  task automatic testBasic();
    clearLog();
    writeTicks = 20'd40;
    doStart(13'h0123);
    doByte(8'hA0); doByte(8'hA1); doByte(8'hA2);
    doCommit();
    repeat (60) @(negedge clk);
    chk("R5 basic write count", logN, 3);
    for (int i = 0; i < 3; i++) begin
      chk("R2 basic address", int'(logAddr[i]), 'h123 + i);
      chk("R2 basic data", int'(logData[i]), 'hA0 + i);
    end
    chk("R6 busy length 40", busyCnt, 40);
  endtask

  task automatic testWrap();
    clearLog();
    writeTicks = 20'd10;
    doStart(13'h0FFE);
    doByte(8'h10); doByte(8'h11); doByte(8'h12); doByte(8'h13);
    doCommit();
    repeat (50) @(negedge clk);
    chk("R3 wrap write count", logN, 4);
    chk("R3 wrap addr0", int'(logAddr[0]), 'h0FE0);
    chk("R3 wrap data0", int'(logData[0]), 'h12);
    chk("R3 wrap addr1", int'(logAddr[1]), 'h0FE1);
    chk("R3 wrap data1", int'(logData[1]), 'h13);
    chk("R5 order addr2", int'(logAddr[2]), 'h0FFE);
    chk("R5 order data2", int'(logData[2]), 'h10);
    chk("R5 order addr3", int'(logAddr[3]), 'h0FFF);
    chk("R5 order data3", int'(logData[3]), 'h11);
    chk("R6 busy floor 32", busyCnt, 32);
  endtask

  task automatic testOverwrite();
    clearLog();
    writeTicks = 20'd40;
    doStart(13'h0040);
    for (int i = 0; i < 33; i++) doByte(8'(i + 1));
    doCommit();
    repeat (60) @(negedge clk);
    chk("R4 overwrite count", logN, 32);
    chk("R4 offset0 last value", int'(logData[0]), 'h21);
    chk("R4 offset0 addr", int'(logAddr[0]), 'h0040);
    chk("R4 offset31 value", int'(logData[31]), 'h20);
    chk("R4 offset31 addr", int'(logAddr[31]), 'h005F);
  endtask

  task automatic testAbort();
    clearLog();
    doStart(13'h0300);
    doByte(8'h77); doByte(8'h78);
    doAbort();
    repeat (5) @(negedge clk);
    chk("R7 abort no busy", busyCnt, 0);
    chk("R7 abort no write", logN, 0);
    doCommit();
    repeat (5) @(negedge clk);
    chk("R8 commit after abort no busy", busyCnt, 0);
    chk("R8 commit after abort no write", logN, 0);
    doStart(13'h0555);
    doByte(8'h5A);
    doCommit();
    repeat (60) @(negedge clk);
    chk("R7 fresh session count", logN, 1);
    chk("R7 fresh session addr", int'(logAddr[0]), 'h0555);
    chk("R7 fresh session data", int'(logData[0]), 'h5A);
  endtask

  task automatic testEmpty();
    clearLog();
    doStart(13'h0700);
    doCommit();
    repeat (5) @(negedge clk);
    chk("R8 empty commit busy", busyCnt, 0);
    chk("R8 empty commit write", logN, 0);
  endtask

  task automatic testBusyIgnore();
    clearLog();
    writeTicks = 20'd40;
    doStart(13'h0200);
    doByte(8'hC1); doByte(8'hC2);
    doCommit();
    repeat (3) @(negedge clk);
    doStart(13'h1000);
    doByte(8'hEE);
    doAbort();
    doCommit();
    repeat (60) @(negedge clk);
    chk("R9 busy ignore count", logN, 2);
    chk("R9 busy ignore addr0", int'(logAddr[0]), 'h0200);
    chk("R9 busy ignore data0", int'(logData[0]), 'hC1);
    chk("R9 busy ignore addr1", int'(logAddr[1]), 'h0201);
    chk("R9 busy ignore data1", int'(logData[1]), 'hC2);
    chk("R9 busy length kept", busyCnt, 40);
    clearLog();
    doCommit();
    repeat (5) @(negedge clk);
    chk("R10 recommit no busy", busyCnt, 0);
    chk("R10 recommit no write", logN, 0);
    doByte(8'h99);
    doCommit();
    repeat (5) @(negedge clk);
    chk("R11 idle byte no busy", busyCnt, 0);
    chk("R11 idle byte no write", logN, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nFails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    #1 rstN = 1'b1;
    repeat (2) @(negedge clk);
    testBasic();
    testWrap();
    testOverwrite();
    testAbort();
    testEmpty();
    testBusyIgnore();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule